// File: doc/BRIEF.md
# Debug power and reset status register

This block sits on the debug clock. Through a small APB-style read port it reports two things about the processor core: whether the core is powered and whether it is held in reset. It also keeps two sticky flags. One records that a core reset occurred and the other records that a power-down occurred. Each flag stays set until a debugger reads the status register. The core reset, the power-on reset and the power-down request are asynchronous to the debug clock, so they pass through a synchronizer before the block uses them. The debug-domain reset clears the reset flag and sets the power-down flag.

The same decoder also guards the core power domain. The lower half of the address space belongs to core-domain registers. While the sticky power-down flag is set, an access there is answered inside the block with an error response and is never forwarded. A debugger therefore has to read the status register, which clears the flag, before it can reach any core-domain register. When the flag is clear, the access goes out on `core_psel`, and the core side's data, ready and error are returned unchanged.

Top module: `dps_top`

## Requirements
- R1: A read of the status register (`paddr == STATUS_OFFSET`, default 12'hA14) returns zero in bits [31:4].
- R2: A write to the status register completes with `pready`=1 and `pslverr`=0, and changes no bit of the register.
- R3: Bit 3 (reset-occurred flag) becomes 1 within 3 `pclk` edges after `core_rst_n` or `por_n` goes low. It stays 1 until a read of the register completes, and the read clears it.
- R4: Bit 2 reads 1 while `core_rst_n` or `por_n` is held low, and reads 0 otherwise, after a 2-edge synchronizer delay.
- R5: Bit 1 (power-down-occurred flag) becomes 1 while `pwrdn_req` is high, and a completed read clears it once the request has gone low.
- R6: When a read completes in the same cycle as a set condition, the read returns the old value and the flag is 1 afterwards.
- R7: While `preset_n` is low, bit 3 is 0 and bit 1 is 1, even if a core reset is asserted at the same time. After release the register reads 0x3 when no core reset and no power-down request is present.
- R8: Bit 0 reads 1 when `pwrdn_req` is low (core powered) and 0 when it is high.
- R9: An access with `paddr[11]`=0 while bit 1 is 1 returns `pready`=1, `pslverr`=1 and `prdata`=0, and keeps `core_psel` low.
- R10: An access with `paddr[11]`=0 while bit 1 is 0 drives `core_psel` with `psel` and returns `core_prdata`, `core_pready` and `core_pslverr`.
- R11: A read of any other address with `paddr[11]`=1 returns zero with `pslverr`=0.
- R12: Only a completed read (`psel`, `penable` and `pready` high, `pwrite` low) clears a sticky flag. A setup-phase cycle alone clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Debug clock |
| preset_n | input | 1 | Debug-domain reset, active low, asynchronous |
| psel | input | 1 | Select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | ADDR_W | Word address; MSB 0 selects the core domain |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer ready |
| pslverr | output | 1 | Error response |
| core_rst_n | input | 1 | Core reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pwrdn_req | input | 1 | Power-down request, asynchronous level |
| core_psel | output | 1 | Forwarded select to core-domain registers |
| core_prdata | input | DATA_W | Read data from core-domain registers |
| core_pready | input | 1 | Ready from core-domain registers |
| core_pslverr | input | 1 | Error from core-domain registers |

## Verification
The assertions assume that each asynchronous input holds its level for at least three `pclk` cycles. Shorter pulses may be lost in the synchronizer, and the set properties then describe synchronized levels that never appeared. The assertions also assume that `paddr` and `pwrite` stay stable from the setup phase through completion, so that the response follows the decode. The stimulus changes the reset and power-down inputs only between transfers and holds each new level for at least five cycles before it reads. It keeps to ordinary setup-then-access ordering, with one exception: a setup-only cycle on the status address, issued on purpose to show that it clears nothing.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
    localparam int STATUS_BITS = 4;
    localparam int BIT_RST_STICKY = 3;
    localparam int BIT_RST_LIVE   = 2;
    localparam int BIT_PD_STICKY  = 1;
    localparam int BIT_PWR_UP     = 0;

    typedef struct packed {
        logic sticky_rst;
        logic sticky_pd;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{sticky_rst: 1'b0, sticky_pd: 1'b1};
endpackage

// File: rtl/dps_sync.sv
`timescale 1ns/1ps
module dps_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.stg[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.stg[i] = sync_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                sync_q.stg[i] <= RST_VAL;
            end
        end else begin
            sync_q <= sync_d;
        end
    end

    assign q = sync_q.stg[STAGES-1];
endmodule

// File: rtl/dps_flags.sv
`timescale 1ns/1ps
module dps_flags
    import dps_pkg::*;
(
    input  logic pclk,
    input  logic preset_n,
    input  logic rst_live,
    input  logic pd_live,
    input  logic rd_clear,
    output logic sticky_rst_q,
    output logic sticky_pd_q
);
    flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (rd_clear) begin
            flags_d.sticky_rst = 1'b0;
            flags_d.sticky_pd  = 1'b0;
        end
        // set condition beats a same-cycle clear
        if (rst_live) flags_d.sticky_rst = 1'b1;
        if (pd_live)  flags_d.sticky_pd  = 1'b1;
    end

    always_ff @(posedge pclk or negedge preset_n) begin
        if (!preset_n) flags_q <= FLAGS_RESET;
        else           flags_q <= flags_d;
    end

    assign sticky_rst_q = flags_q.sticky_rst;
    assign sticky_pd_q  = flags_q.sticky_pd;
endmodule

// File: rtl/dps_decode.sv
`timescale 1ns/1ps
module dps_decode
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'hA14
) (
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [STATUS_BITS-1:0] status_word,
    input  logic                   sticky_pd,
    input  logic [DATA_W-1:0]      core_prdata,
    input  logic                   core_pready,
    input  logic                   core_pslverr,
    output logic [DATA_W-1:0]      prdata,
    output logic                   pready,
    output logic                   pslverr,
    output logic                   core_psel,
    output logic                   hit_status,
    output logic                   hit_core,
    output logic                   rd_clear
);
    always_comb begin
        hit_core   = ~paddr[ADDR_W-1];
        hit_status = (paddr == STATUS_OFFSET);
        core_psel  = psel & hit_core & ~sticky_pd;
        prdata     = '0;
        pready     = 1'b1;
        pslverr    = 1'b0;
        if (hit_core) begin
            if (sticky_pd) begin
                pslverr = psel & penable;
            end else begin
                prdata  = core_prdata;
                pready  = core_pready;
                pslverr = core_pslverr;
            end
        end else if (hit_status && !pwrite) begin
            prdata[STATUS_BITS-1:0] = status_word;
        end
        rd_clear = psel & penable & pready & ~pwrite & hit_status;
    end
endmodule

// File: rtl/dps_top.sv
`timescale 1ns/1ps
module dps_top
    import dps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] STATUS_OFFSET = 12'hA14
) (
    input  logic              pclk,
    input  logic              preset_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              core_rst_n,
    input  logic              por_n,
    input  logic              pwrdn_req,
    output logic              core_psel,
    input  logic [DATA_W-1:0] core_prdata,
    input  logic              core_pready,
    input  logic              core_pslverr
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0]       raw_in, synced;
    logic                   rst_live, pd_live;
    logic                   sticky_rst_q, sticky_pd_q;
    logic                   hit_status, hit_core, rd_clear;
    logic [STATUS_BITS-1:0] status_word;

    assign raw_in = {pwrdn_req, ~core_rst_n | ~por_n};

    dps_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
        .clk(pclk), .rst_n(preset_n), .d(raw_in), .q(synced)
    );

    assign rst_live = synced[0];
    assign pd_live  = synced[1];

    dps_flags u_flags (
        .pclk(pclk), .preset_n(preset_n), .rst_live(rst_live), .pd_live(pd_live),
        .rd_clear(rd_clear), .sticky_rst_q(sticky_rst_q), .sticky_pd_q(sticky_pd_q)
    );

    always_comb begin
        status_word = '0;
        status_word[BIT_RST_STICKY] = sticky_rst_q;
        status_word[BIT_RST_LIVE]   = rst_live;
        status_word[BIT_PD_STICKY]  = sticky_pd_q;
        status_word[BIT_PWR_UP]     = ~pd_live;
    end

    dps_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_OFFSET(STATUS_OFFSET)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .status_word(status_word), .sticky_pd(sticky_pd_q),
        .core_prdata(core_prdata), .core_pready(core_pready), .core_pslverr(core_pslverr),
        .prdata(prdata), .pready(pready), .pslverr(pslverr), .core_psel(core_psel),
        .hit_status(hit_status), .hit_core(hit_core), .rd_clear(rd_clear)
    );
endmodule

// File: rtl/dps_checker.sv
`timescale 1ns/1ps
module dps_checker #(
    parameter int DATA_W = 32
) (
    input logic              pclk,
    input logic              preset_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              pready,
    input logic              pslverr,
    input logic [DATA_W-1:0] prdata,
    input logic              core_psel,
    input logic              hit_status,
    input logic              hit_core,
    input logic              rd_clear,
    input logic              rst_live,
    input logic              pd_live,
    input logic              sticky_rst_q,
    input logic              sticky_pd_q
);
    assert_rsvd_zero_R1: assert property (@(posedge pclk) disable iff (!preset_n)
        (psel && penable && !pwrite && hit_status) |-> (prdata[DATA_W-1:4] == '0));

    assert_clear_on_read_R3: assert property (@(posedge pclk) disable iff (!preset_n)
        (rd_clear && !rst_live) |=> !sticky_rst_q);

    assert_hold_without_read_R12: assert property (@(posedge pclk) disable iff (!preset_n)
        (!rd_clear && !rst_live) |=> $stable(sticky_rst_q));

    assert_live_bits_R4: assert property (@(posedge pclk) disable iff (!preset_n)
        (psel && penable && !pwrite && hit_status) |-> (prdata[2] == rst_live && prdata[0] == !pd_live));

    assert_set_wins_R6: assert property (@(posedge pclk) disable iff (!preset_n)
        rst_live |=> sticky_rst_q);

    assert_pd_sets_R5: assert property (@(posedge pclk) disable iff (!preset_n)
        pd_live |=> sticky_pd_q);

    assert_blocked_err_R9: assert property (@(posedge pclk) disable iff (!preset_n)
        (psel && penable && hit_core && sticky_pd_q) |-> (pslverr && pready && !core_psel && prdata == '0));

    assert_forward_R10: assert property (@(posedge pclk) disable iff (!preset_n)
        (psel && hit_core && !sticky_pd_q) |-> core_psel);
endmodule

bind dps_top dps_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dps_top.sv
`timescale 1ns/1ps
module sim_dps_top;
    logic        pclk = 1'b0;
    logic        preset_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, core_psel;
    logic        core_rst_n = 1'b1, por_n = 1'b1, pwrdn_req = 1'b0;
    logic [31:0] core_prdata;
    logic        core_pready = 1'b1, core_pslverr = 1'b0;

    localparam logic [11:0] A_STAT = 12'hA14;
    localparam logic [11:0] A_CORE = 12'h088;
    localparam logic [11:0] A_FREE = 12'hA18;
    localparam logic [31:0] CORE_TAG = 32'hC0DE_0000;

    int vectors = 0;
    int fails = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        logic        fwd;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 pclk = ~pclk;

    assign core_prdata = CORE_TAG | {20'h0, paddr};

    dps_top u0 (
        .pclk(pclk), .preset_n(preset_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .core_rst_n(core_rst_n), .por_n(por_n),
        .pwrdn_req(pwrdn_req), .core_psel(core_psel), .core_prdata(core_prdata),
        .core_pready(core_pready), .core_pslverr(core_pslverr)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // monitor: compares each completed read against the queue head
    always @(negedge pclk) begin
        if (preset_n && psel && penable && pready && !pwrite) begin
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: actual %h expected none", prdata);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (prdata !== e.data || pslverr !== e.err || core_psel !== e.fwd) begin
                    fails++;
                    $display("FAIL %s: actual data=%h err=%b fwd=%b expected data=%h err=%b fwd=%b",
                             e.tag, prdata, pslverr, core_psel, e.data, e.err, e.fwd);
                end
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] ed, input logic ee,
                      input logic ef, input string tag);
        exp_t e;
        e.data = ed; e.err = ee; e.fwd = ef; e.tag = tag;
        exp_q.push_back(e);
        @(posedge pclk); #2;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge pclk); #2;
        penable = 1'b1;
        do @(negedge pclk); while (!pready);
        @(posedge pclk); #2;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input string tag);
        @(posedge pclk); #2;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a;
        @(posedge pclk); #2;
        penable = 1'b1;
        @(negedge pclk);
        vectors++;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            fails++;
            $display("FAIL %s: actual ready=%b err=%b expected ready=1 err=0", tag, pready, pslverr);
        end
        @(posedge pclk); #2;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge pclk);
        #2;
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        preset_n = 1'b1;
        idle(4);
        // reset state and core-domain block
        rd(A_CORE, 32'h0, 1'b1, 1'b0, "R9 blocked after reset");
        rd(A_STAT, 32'h3, 1'b0, 1'b0, "R7 reset value");
        rd(A_STAT, 32'h1, 1'b0, 1'b0, "R5 pd flag cleared by read");
        rd(A_CORE, CORE_TAG | 32'h088, 1'b0, 1'b1, "R10 forwarded");
        rd(A_FREE, 32'h0, 1'b0, 1'b0, "R11 unmapped reads zero");

        // core reset held
        core_rst_n = 1'b0; idle(5);
        rd(A_STAT, 32'hD, 1'b0, 1'b0, "R4 live reset with R3 sticky");
        rd(A_STAT, 32'hD, 1'b0, 1'b0, "R6 set wins over clear");
        core_rst_n = 1'b1; idle(5);
        rd(A_STAT, 32'h9, 1'b0, 1'b0, "R3 sticky after release");
        rd(A_STAT, 32'h1, 1'b0, 1'b0, "R3 cleared by read");

        // power-on reset pulse
        por_n = 1'b0; idle(5); por_n = 1'b1; idle(5);
        rd(A_STAT, 32'h9, 1'b0, 1'b0, "R3 por sets flag");
        rd(A_STAT, 32'h1, 1'b0, 1'b0, "R3 por flag cleared");

        // power-down request
        pwrdn_req = 1'b1; idle(5);
        rd(A_STAT, 32'h2, 1'b0, 1'b0, "R8 powered-down status");
        rd(A_STAT, 32'h2, 1'b0, 1'b0, "R6 pd set wins");
        rd(A_CORE, 32'h0, 1'b1, 1'b0, "R9 blocked during power-down");
        pwrdn_req = 1'b0; idle(5);
        rd(A_STAT, 32'h3, 1'b0, 1'b0, "R5 pd sticky after release");
        rd(A_STAT, 32'h1, 1'b0, 1'b0, "R5 pd cleared");
        rd(A_CORE, CORE_TAG | 32'h088, 1'b0, 1'b1, "R10 forwarded again");

        // writes ignored
        wr(A_STAT, "R2 write response");
        rd(A_STAT, 32'h1, 1'b0, 1'b0, "R2 write no effect");
        core_rst_n = 1'b0; idle(5); core_rst_n = 1'b1; idle(5);
        wr(A_STAT, "R2 write response");
        rd(A_STAT, 32'h9, 1'b0, 1'b0, "R2 write keeps flag");

        // setup-only cycle does not clear
        core_rst_n = 1'b0; idle(5); core_rst_n = 1'b1; idle(5);
        @(posedge pclk); #2;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = A_STAT;
        @(posedge pclk); #2;
        psel = 1'b0;
        idle(2);
        rd(A_STAT, 32'h9, 1'b0, 1'b0, "R12 setup phase alone");
        rd(A_STAT, 32'h1, 1'b0, 1'b0, "R12 completed read clears");

        // debug reset with core reset together
        core_rst_n = 1'b0; preset_n = 1'b0; idle(4);
        core_rst_n = 1'b1; idle(2);
        preset_n = 1'b1; idle(5);
        rd(A_CORE, 32'h0, 1'b1, 1'b0, "R9 blocked after debug reset");
        rd(A_STAT, 32'h3, 1'b0, 1'b0, "R7 debug reset priority");

        idle(3);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule